// File: doc/BRIEF.md
# Instruction-Cycle Machine-Cycle Sequencer

This block is the instruction-level controller that sits above a bus machine-cycle generator. It keeps a program counter and four 8-bit registers: accumulator, B, H and L. Every instruction begins with an opcode fetch at the program counter. The fetched byte is decoded, and the block then issues the further machine cycles that the instruction needs, one request at a time. It also adds up the T-states that each instruction used and reports the total when the instruction retires.

Each machine cycle is a request/done handshake. The sequencer raises `bus_req` with a cycle kind, an address and write data, and holds them until the bus generator pulses `bus_done`. For read cycles, `bus_rdata` is sampled in the same clock as `bus_done`. Debug outputs show the program counter and the registers.

State machine: states FETCH, DECODE, OPND_LO, OPND_HI, HL_READ, IO_READ, IO_WRITE, MEM_WRITE and RETIRE. Reset enters FETCH. The transitions are:
- FETCH→DECODE on done.
- DECODE→RETIRE for an unsupported opcode.
- DECODE→HL_READ for the register-indirect load.
- DECODE→OPND_LO for every other instruction.
- OPND_LO on done: →RETIRE for an immediate load, →IO_READ for input, →IO_WRITE for output, →OPND_HI for a direct store.
- OPND_HI→MEM_WRITE on done.
- HL_READ, IO_READ, IO_WRITE and MEM_WRITE each go →RETIRE on done.
- RETIRE→FETCH unconditionally.

Top module: `instr_sequencer`

## Requirements
- R1: After reset the program counter is RESET_PC (0), all registers are 0, and the first request is an opcode fetch (kind 0) at the program counter; every instruction starts with such a fetch.
- R2: While `bus_req` is high and `bus_done` is low, the kind, address and write data stay unchanged in the next clock. Kind codes: 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write.
- R3: Opcodes 0x3E, 0x06, 0x26 and 0x2E (immediate load into A, B, H and L) issue a fetch and then one memory read at the program counter. The byte read goes into the selected register. The instruction takes 7 T-states.
- R4: Opcode 0x46 issues a fetch and then a memory read at address {H,L}. The byte read goes into B. The instruction takes 7 T-states.
- R5: Opcode 0xDB issues a fetch, a memory read of the port byte at the program counter, and an I/O read whose data goes into the accumulator. The instruction takes 10 T-states.
- R6: Opcode 0xD3 issues a fetch, a memory read of the port byte, and an I/O write of the accumulator. The instruction takes 10 T-states.
- R7: In an I/O read or I/O write, the port number appears on both address byte lanes: bits 15:8 equal bits 7:0.
- R8: Opcode 0x32 issues a fetch, two memory reads at the program counter (low address byte first), and a memory write of the accumulator to {high,low}. The instruction takes 13 T-states.
- R9: The program counter advances by one after the fetch and after each operand read. It holds through the {H,L} read, the I/O cycles and the memory write.
- R10: At retire, `instr_done` is high for exactly one clock. At that time `instr_tstates` equals 4 for the fetch plus 3 for each further machine cycle.
- R11: Any other opcode is a one-cycle no-op. It issues only the fetch, reports 4 T-states, advances the program counter by one and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Machine-cycle request |
| bus_kind | output | 3 | Machine-cycle kind code |
| bus_addr | output | ADDR_W | Cycle address |
| bus_wdata | output | DATA_W | Write data for write cycles |
| bus_done | input | 1 | Cycle completion pulse |
| bus_rdata | input | DATA_W | Read data, valid with bus_done |
| instr_done | output | 1 | One-clock retire pulse |
| instr_tstates | output | TW | T-states of the retiring instruction |
| dbg_pc | output | ADDR_W | Program counter |
| dbg_acc | output | DATA_W | Accumulator |
| dbg_b | output | DATA_W | Register B |
| dbg_h | output | DATA_W | Register H |
| dbg_l | output | DATA_W | Register L |

## Verification
Some properties are checked by assertions on every cycle:
- the request holds steady until done, and the next request after a retire is a fetch;
- an I/O cycle carries the same byte on both address lanes;
- the program counter steps after a fetch and holds across I/O and write cycles;
- every retire reports a T-state total that is a legal sum of 4 plus multiples of 3.

Other behaviour only the bench scenarios can show. This covers which exact cycles each opcode issues and in what order, the operand byte ordering of the direct store, the data that ends up in each register, and the exact T-state total for each instruction. The bench runs a program that mixes every opcode with varied handshake latency and checks it against a behavioural model.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        CYC_FETCH = 3'd0,
        CYC_MRD   = 3'd1,
        CYC_MWR   = 3'd2,
        CYC_IORD  = 3'd3,
        CYC_IOWR  = 3'd4
    } cyc_e;

    typedef enum logic [2:0] {
        OPC_NONE,
        OPC_MVI,
        OPC_MOVBM,
        OPC_IN,
        OPC_OUT,
        OPC_STA
    } opc_e;

    typedef enum logic [1:0] {
        DST_A,
        DST_B,
        DST_H,
        DST_L
    } dst_e;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPND_LO,
        ST_OPND_HI,
        ST_HL_READ,
        ST_IO_READ,
        ST_IO_WRITE,
        ST_MEM_WRITE,
        ST_RETIRE
    } st_e;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [7:0] opcode,
    output opc_e       cls,
    output dst_e       dst
);
    always_comb begin
        cls = OPC_NONE;
        dst = DST_A;
        unique case (opcode)
            8'h3E: begin cls = OPC_MVI; dst = DST_A; end
            8'h06: begin cls = OPC_MVI; dst = DST_B; end
            8'h26: begin cls = OPC_MVI; dst = DST_H; end
            8'h2E: begin cls = OPC_MVI; dst = DST_L; end
            8'h46: cls = OPC_MOVBM;
            8'hDB: cls = OPC_IN;
            8'hD3: cls = OPC_OUT;
            8'h32: cls = OPC_STA;
            default: cls = OPC_NONE;
        endcase
    end
endmodule

// File: rtl/seq_tcount.sv
module seq_tcount #(
    parameter int TW      = 6,
    parameter int FETCH_T = 4,
    parameter int OTHER_T = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          add,
    output logic [TW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (start) count <= TW'(FETCH_T);
        else if (add)   count <= count + TW'(OTHER_T);
    end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int RESET_PC = 0,
    parameter int TW       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              bus_req,
    output logic [2:0]        bus_kind,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              instr_done,
    output logic [TW-1:0]     instr_tstates,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [DATA_W-1:0] dbg_acc,
    output logic [DATA_W-1:0] dbg_b,
    output logic [DATA_W-1:0] dbg_h,
    output logic [DATA_W-1:0] dbg_l
);
    localparam int HALF_W = ADDR_W / 2;

    st_e              state, state_nx;
    opc_e             cls;
    dst_e             dst;
    logic [DATA_W-1:0] opcode, opr_lo, opr_hi;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] acc, rb, rh, rl;
    logic              xfer;
    cyc_e              kind;

    assign xfer = bus_req && bus_done;

    seq_decode u_dec (
        .opcode (opcode),
        .cls    (cls),
        .dst    (dst)
    );

    seq_tcount #(.TW(TW), .FETCH_T(4), .OTHER_T(3)) u_tcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (xfer && state == ST_FETCH),
        .add   (xfer && state != ST_FETCH),
        .count (instr_tstates)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:   if (xfer) state_nx = ST_DECODE;
            ST_DECODE: begin
                if (cls == OPC_NONE)       state_nx = ST_RETIRE;
                else if (cls == OPC_MOVBM) state_nx = ST_HL_READ;
                else                       state_nx = ST_OPND_LO;
            end
            ST_OPND_LO: if (xfer) begin
                if (cls == OPC_IN)       state_nx = ST_IO_READ;
                else if (cls == OPC_OUT) state_nx = ST_IO_WRITE;
                else if (cls == OPC_STA) state_nx = ST_OPND_HI;
                else                     state_nx = ST_RETIRE;
            end
            ST_OPND_HI:   if (xfer) state_nx = ST_MEM_WRITE;
            ST_HL_READ,
            ST_IO_READ,
            ST_IO_WRITE,
            ST_MEM_WRITE: if (xfer) state_nx = ST_RETIRE;
            ST_RETIRE:    state_nx = ST_FETCH;
            default:      state_nx = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= ADDR_W'(RESET_PC);
            opcode <= '0;
            opr_lo <= '0;
            opr_hi <= '0;
            acc    <= '0;
            rb     <= '0;
            rh     <= '0;
            rl     <= '0;
        end else if (xfer) begin
            unique case (state)
                ST_FETCH: begin
                    opcode <= bus_rdata;
                    pc     <= pc + 1'b1;
                end
                ST_OPND_LO: begin
                    opr_lo <= bus_rdata;
                    pc     <= pc + 1'b1;
                    if (cls == OPC_MVI) begin
                        unique case (dst)
                            DST_A: acc <= bus_rdata;
                            DST_B: rb  <= bus_rdata;
                            DST_H: rh  <= bus_rdata;
                            DST_L: rl  <= bus_rdata;
                        endcase
                    end
                end
                ST_OPND_HI: begin
                    opr_hi <= bus_rdata;
                    pc     <= pc + 1'b1;
                end
                ST_HL_READ: rb  <= bus_rdata;
                ST_IO_READ: acc <= bus_rdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_req    = 1'b1;
        kind       = CYC_FETCH;
        bus_addr   = pc;
        bus_wdata  = '0;
        instr_done = 1'b0;
        unique case (state)
            ST_FETCH:     ;
            ST_OPND_LO,
            ST_OPND_HI:   kind = CYC_MRD;
            ST_HL_READ: begin
                kind     = CYC_MRD;
                bus_addr = {rh[HALF_W-1:0], rl[HALF_W-1:0]};
            end
            ST_IO_READ: begin
                kind     = CYC_IORD;
                bus_addr = {opr_lo[HALF_W-1:0], opr_lo[HALF_W-1:0]};
            end
            ST_IO_WRITE: begin
                kind      = CYC_IOWR;
                bus_addr  = {opr_lo[HALF_W-1:0], opr_lo[HALF_W-1:0]};
                bus_wdata = acc;
            end
            ST_MEM_WRITE: begin
                kind      = CYC_MWR;
                bus_addr  = {opr_hi[HALF_W-1:0], opr_lo[HALF_W-1:0]};
                bus_wdata = acc;
            end
            ST_RETIRE: begin
                bus_req    = 1'b0;
                instr_done = 1'b1;
            end
            default: bus_req = 1'b0;
        endcase
    end

    assign bus_kind = kind;
    assign dbg_pc   = pc;
    assign dbg_acc  = acc;
    assign dbg_b    = rb;
    assign dbg_h    = rh;
    assign dbg_l    = rl;

    AST_FETCH_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> bus_req && bus_kind == 3'd0 && !instr_done); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_kind) && $stable(bus_addr)
                                 && $stable(bus_wdata)); // R2

    AST_IO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_kind == 3'd3 || bus_kind == 3'd4)
            |-> bus_addr[ADDR_W-1:HALF_W] == bus_addr[HALF_W-1:0]); // R7

    AST_PC_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && bus_kind == 3'd0 |=> dbg_pc == $past(dbg_pc) + 1'b1); // R9

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && bus_kind >= 3'd2 |=> $stable(dbg_pc)); // R9

    AST_TSTATE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> instr_tstates inside {TW'(4), TW'(7), TW'(10), TW'(13),
                                             TW'(16), TW'(19)}); // R10

endmodule

// File: tb/instr_sequencer_tb.sv
module instr_sequencer_tb;

    localparam int N_INSTR = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req;
    logic [2:0]  bus_kind;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_done = 1'b0;
    logic [7:0]  bus_rdata = 8'h00;
    logic        instr_done;
    logic [5:0]  instr_tstates;
    logic [15:0] dbg_pc;
    logic [7:0]  dbg_acc, dbg_b, dbg_h, dbg_l;

    always #2.5 clk = ~clk;

    instr_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .instr_done(instr_done), .instr_tstates(instr_tstates),
        .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_b(dbg_b),
        .dbg_h(dbg_h), .dbg_l(dbg_l)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int retired  = 0;
    int cycles   = 0;
    int txn_idx  = 0;
    int wait_cnt = 0;

    logic [7:0]  mem [0:255];
    logic [26:0] exp_q [$];
    string       tag_q [$];
    logic        seen_front = 1'b0;
    logic        expect_retire = 1'b0;

    logic [15:0] m_pc = 16'h0000;
    logic [7:0]  m_a = 8'h00, m_b = 8'h00, m_h = 8'h00, m_l = 8'h00;
    int          m_t = 0;
    string       m_tag = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [15:0] a);
        if (a[15:8] == 8'h00) return mem[a[7:0]];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic push(input logic [2:0] k, input logic [15:0] a,
                        input logic [7:0] w, input string tag);
        exp_q.push_back({k, a, w});
        tag_q.push_back(tag);
    endtask

    task automatic plan();
        logic [7:0] op, v, lo, hi;
        op = rd(m_pc);
        push(3'd0, m_pc, 8'h00, "R1");
        m_pc = m_pc + 1;
        m_t = 4;
        case (op)
            8'h3E, 8'h06, 8'h26, 8'h2E: begin
                v = rd(m_pc);
                push(3'd1, m_pc, 8'h00, "R3");
                m_pc = m_pc + 1;
                m_t = 7;
                m_tag = "R3";
                case (op)
                    8'h3E: m_a = v;
                    8'h06: m_b = v;
                    8'h26: m_h = v;
                    default: m_l = v;
                endcase
            end
            8'h46: begin
                push(3'd1, {m_h, m_l}, 8'h00, "R4");
                m_b = rd({m_h, m_l});
                m_t = 7;
                m_tag = "R4";
            end
            8'hDB: begin
                v = rd(m_pc);
                push(3'd1, m_pc, 8'h00, "R5");
                m_pc = m_pc + 1;
                push(3'd3, {v, v}, 8'h00, "R7");
                m_a = v ^ 8'hC3;
                m_t = 10;
                m_tag = "R5";
            end
            8'hD3: begin
                v = rd(m_pc);
                push(3'd1, m_pc, 8'h00, "R6");
                m_pc = m_pc + 1;
                push(3'd4, {v, v}, m_a, "R7");
                m_t = 10;
                m_tag = "R6";
            end
            8'h32: begin
                lo = rd(m_pc);
                push(3'd1, m_pc, 8'h00, "R8");
                m_pc = m_pc + 1;
                hi = rd(m_pc);
                push(3'd1, m_pc, 8'h00, "R8");
                m_pc = m_pc + 1;
                push(3'd2, {hi, lo}, m_a, "R8");
                m_t = 13;
                m_tag = "R8";
            end
            default: m_tag = "R11";
        endcase
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            if (bus_done) begin
                bus_done = 1'b0;
                wait_cnt = 0;
            end else if (bus_req) begin
                if (exp_q.size() == 0) begin
                    chk(!expect_retire, "R10", "fetch before retire", {31'd0, bus_req}, 32'd0);
                    plan();
                    seen_front = 1'b0;
                end
                begin
                    logic [26:0] e;
                    logic [26:0] a;
                    e = exp_q[0];
                    a = {bus_kind, bus_addr, (e[26:24] == 3'd2 || e[26:24] == 3'd4) ? bus_wdata : 8'h00};
                    chk(a == e, seen_front ? "R2" : tag_q[0], "bus cycle", {5'd0, a}, {5'd0, e});
                    seen_front = 1'b1;
                    wait_cnt++;
                    if (wait_cnt >= 1 + (txn_idx % 3)) begin
                        bus_done = 1'b1;
                        case (e[26:24])
                            3'd0, 3'd1: bus_rdata = rd(e[23:8]);
                            3'd3:       bus_rdata = e[15:8] ^ 8'hC3;
                            default:    bus_rdata = 8'hEE;
                        endcase
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                        seen_front = 1'b0;
                        txn_idx++;
                        if (exp_q.size() == 0) expect_retire = 1'b1;
                    end
                end
            end
            if (instr_done) begin
                chk(expect_retire, "R10", "retire pulse", 32'd1, {31'd0, expect_retire});
                if (expect_retire) begin
                    chk(instr_tstates == 6'(m_t), "R10", "tstates", {26'd0, instr_tstates}, m_t);
                    chk(dbg_pc == m_pc, "R9", "pc", {16'd0, dbg_pc}, {16'd0, m_pc});
                    chk({dbg_acc, dbg_b, dbg_h, dbg_l} == {m_a, m_b, m_h, m_l}, m_tag,
                        "registers A,B,H,L", {dbg_acc, dbg_b, dbg_h, dbg_l}, {m_a, m_b, m_h, m_l});
                end
                expect_retire = 1'b0;
                retired++;
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h00] = 8'h3E; mem[8'h01] = 8'h5A;
        mem[8'h02] = 8'h26; mem[8'h03] = 8'h01;
        mem[8'h04] = 8'h2E; mem[8'h05] = 8'h23;
        mem[8'h06] = 8'h46;
        mem[8'h07] = 8'hDB; mem[8'h08] = 8'h40;
        mem[8'h09] = 8'hD3; mem[8'h0A] = 8'h7F;
        mem[8'h0B] = 8'h32; mem[8'h0C] = 8'h34; mem[8'h0D] = 8'h12;
        mem[8'h0E] = 8'hFF;
        mem[8'h0F] = 8'h06; mem[8'h10] = 8'h99;
        mem[8'h11] = 8'h00;
        mem[8'h12] = 8'h2E; mem[8'h13] = 8'h10;
        mem[8'h14] = 8'h26; mem[8'h15] = 8'h00;
        mem[8'h16] = 8'h46;
        mem[8'h17] = 8'hD3; mem[8'h18] = 8'h00;
        mem[8'h19] = 8'h32; mem[8'h1A] = 8'hFF; mem[8'h1B] = 8'hFF;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dbg_pc == 16'h0000, "R1", "reset pc", {16'd0, dbg_pc}, 32'd0);
        chk({dbg_acc, dbg_b, dbg_h, dbg_l} == 32'd0, "R1", "reset registers",
            {dbg_acc, dbg_b, dbg_h, dbg_l}, 32'd0);
        chk(!instr_done, "R10", "no retire in reset", {31'd0, instr_done}, 32'd0);
        chk(bus_req && bus_kind == 3'd0, "R1", "first request is fetch",
            {28'd0, bus_req, bus_kind}, 32'h8);
        rst_n = 1'b1;

        while (retired < N_INSTR && cycles < 20000) @(negedge clk);
        chk(retired == N_INSTR, "R10", "watchdog: instructions retired", retired, N_INSTR);
        chk(exp_q.size() == 0, "R2", "pending expected cycles", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule